// File: doc/BRIEF.md
# Masked Priority Interrupt Controller with Vector Delivery

This block gathers interrupt requests from a parameterised number of devices. Each device has a dedicated request line. Any line that is raised is latched into a pending register, and it stays there until the processor acknowledges it. A software-writable mask decides which pending lines are allowed to reach the processor. A mask bit of one blocks its line and a mask bit of zero lets it through. The single interrupt output to the processor is high whenever any pending line is unmasked.

When the processor acknowledges, the block picks the unmasked pending line with the best fixed priority and returns the service-routine address for that line. Line 0 has the best priority, and priority falls as the index rises. The address comes from a per-line vector register that software programs. The processor can therefore jump directly to the right routine without polling devices. The pending bit of the chosen line is cleared on the clock edge that accepts the acknowledge.

A small register port gives read and write access to the mask and the vector table, and read-only access to the pending register.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask reads as all ones and the pending register reads as zero. Every vector register reads as zero and `irq_out` is low.
- R2: A request line that is high at a rising clock edge sets its pending bit at that edge. The bit stays set after the request drops, and only an acknowledge that grants that line clears it.
- R3: A line whose mask bit is 1 has no effect on `irq_out` and is never selected. Its pending bit is still recorded and can be read.
- R4: `irq_out` is high exactly when at least one pending line has its mask bit at 0. It follows the registered state, so a request shows on `irq_out` one cycle after the edge that latched it.
- R5: When several unmasked lines are pending, the line with the lowest index is selected.
- R6: `irq_vector` shows the vector register of the selected line, or zero when no line is selected. `irq_vec_valid` is high in any cycle where `irq_ack` is high and `irq_out` is high.
- R7: An accepted acknowledge clears the selected line's pending bit at that clock edge, and the clear takes precedence over that line's request in that cycle. A request that is still held sets the bit again at the following edge.
- R8: Register map:
  - address 0 is the mask, read and write, with bit i controlling line i;
  - address 1 is the pending register, read-only, and writes to it are ignored;
  - address 2+i is the vector for line i, read and write;
  - any other address reads as zero.

  `reg_rdata` is combinational from `reg_addr`. Writes take effect at the clock edge.
- R9: An acknowledge while `irq_out` is low leaves the pending register unchanged, and `irq_vec_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_LINES | Level request, one bit per device |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | Acknowledge from the processor |
| irq_vector | output | DATA_W | Service-routine address of the selected line |
| irq_vec_valid | output | 1 | Acknowledge accepted this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (ADDR_W = clog2(NUM_LINES+2)) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |

## Verification
The three kinds of internal fault show up at different ports:
- A wrong pending bit shows one cycle after the faulty edge, both on `irq_out` and in a read of address 1.
- A wrong priority choice or a stale vector shows at once on `irq_vector` in the same cycle.
- A failed clear at acknowledge shows in the next cycle as the same vector being presented again.

The masked-but-pending case and the held-request re-arm are the two states that only the pending read exposes. The bench therefore reads that register around each of them.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int ADDR_MASK     = 0;
   localparam int ADDR_PEND     = 1;
   localparam int ADDR_VEC_BASE = 2;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ivc_pend.sv
module ivc_pend #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req,
   input  logic [NUM_LINES-1:0] clr,
   output logic [NUM_LINES-1:0] pend
);
   logic [NUM_LINES-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q | req) & ~clr;
   end

   assign pend = pend_q;

   // R2: a pending bit not being cleared stays set
   p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0));
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
   parameter int NUM_LINES = 8,
   localparam int IW = ivc_pkg::idx_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] active,
   output logic [NUM_LINES-1:0] grant,
   output logic [IW-1:0]        idx
);
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (active[i]) begin
            grant  = '0;
            grant[i] = 1'b1;
            idx    = IW'(i);
         end
      end
   end

   p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~active) == '0));
   // R5: no active line below the granted one
   p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> ((active & (grant - 1'b1)) == '0));
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs #(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 16,
   localparam int IW = ivc_pkg::idx_width(NUM_LINES),
   localparam int AW = $clog2(NUM_LINES + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [AW-1:0]        addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_LINES-1:0] pend,
   input  logic [IW-1:0]        sel_idx,
   output logic [NUM_LINES-1:0] mask,
   output logic [DATA_W-1:0]    sel_vec,
   output logic [DATA_W-1:0]    rdata
);
   import ivc_pkg::*;

   logic [NUM_LINES-1:0] mask_q;
   logic [DATA_W-1:0]    vec_q [NUM_LINES];

   always_ff @(posedge clk) begin
      if (!rst_n)                               mask_q <= '1;
      else if (wr && addr == AW'(ADDR_MASK))    mask_q <= wdata[NUM_LINES-1:0];
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_vec
      always_ff @(posedge clk) begin
         if (!rst_n)                                      vec_q[g] <= '0;
         else if (wr && addr == AW'(ADDR_VEC_BASE + g))   vec_q[g] <= wdata;
      end
   end

   always_comb begin
      sel_vec = '0;
      for (int i = 0; i < NUM_LINES; i++)
         if (sel_idx == IW'(i)) sel_vec = vec_q[i];
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(ADDR_MASK))      rdata = DATA_W'(mask_q);
      else if (addr == AW'(ADDR_PEND)) rdata = DATA_W'(pend);
      for (int i = 0; i < NUM_LINES; i++)
         if (addr == AW'(ADDR_VEC_BASE + i)) rdata = vec_q[i];
   end

   assign mask = mask_q;

   // R8: mask changes only through a write to its address
   p_mask_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == AW'(ADDR_MASK)) |=> $stable(mask_q));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int NUM_LINES = 8,
   parameter int DATA_W    = 16,
   localparam int ADDR_W   = $clog2(NUM_LINES + 2),
   localparam int IW       = ivc_pkg::idx_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req,
   output logic                 irq_out,
   input  logic                 irq_ack,
   output logic [DATA_W-1:0]    irq_vector,
   output logic                 irq_vec_valid,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata
);
   if (NUM_LINES < 1)      begin : g_bad_lines $error("NUM_LINES must be at least 1"); end
   if (DATA_W < NUM_LINES) begin : g_bad_width $error("DATA_W must cover NUM_LINES"); end

   logic [NUM_LINES-1:0] pend, mask, active, grant, clr;
   logic [IW-1:0]        sel_idx;
   logic [DATA_W-1:0]    sel_vec;

   ivc_pend #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(clr), .pend(pend));

   assign active  = pend & ~mask;
   assign irq_out = |active;

   ivc_prio #(.NUM_LINES(NUM_LINES)) u_prio (
      .clk(clk), .rst_n(rst_n), .active(active), .grant(grant), .idx(sel_idx));

   ivc_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .pend(pend), .sel_idx(sel_idx), .mask(mask), .sel_vec(sel_vec),
      .rdata(reg_rdata));

   assign clr           = irq_ack ? grant : '0;
   assign irq_vec_valid = irq_ack & irq_out;
   assign irq_vector    = irq_out ? sel_vec : '0;

   p_out_matches_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (grant != '0));
   p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & mask) == '0);
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_out) |=> ((pend & $past(grant)) == '0));
   p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_out) |=> ((pend & ~$past(pend)) == ($past(irq_req) & ~$past(pend))));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
   localparam int N  = 8;
   localparam int DW = 16;
   localparam int AW = $clog2(N + 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic          irq_ack = 1'b0, reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic          irq_out, irq_vec_valid;
   logic [DW-1:0] irq_vector, reg_rdata;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl #(.NUM_LINES(N), .DATA_W(DW)) u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_out(irq_out),
      .irq_ack(irq_ack), .irq_vector(irq_vector), .irq_vec_valid(irq_vec_valid),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference
   logic [N-1:0]  m_mask = '1, m_pend = '0;
   logic [DW-1:0] m_vec [N];

   function automatic int m_sel();
      for (int i = 0; i < N; i++) if (m_pend[i] && !m_mask[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mask = '1; m_pend = '0;
         for (int i = 0; i < N; i++) m_vec[i] = '0;
      end else begin
         int g;
         logic [N-1:0] c;
         g = m_sel();
         c = '0;
         if (irq_ack && g >= 0) c[g] = 1'b1;
         if (reg_wr) begin
            if (int'(reg_addr) == 0) m_mask = reg_wdata[N-1:0];
            else if (int'(reg_addr) >= 2 && int'(reg_addr) < 2 + N) m_vec[int'(reg_addr) - 2] = reg_wdata;
         end
         m_pend = (m_pend | irq_req) & ~c;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int g;
         logic [DW-1:0] er;
         g = m_sel();
         chk("R4 irq_out", 32'(irq_out), 32'(g >= 0));
         chk("R6 irq_vector", 32'(irq_vector), (g >= 0) ? 32'(m_vec[g]) : 32'h0);
         chk("R6 irq_vec_valid", 32'(irq_vec_valid), 32'(irq_ack && g >= 0));
         if (int'(reg_addr) == 0)      er = DW'(m_mask);
         else if (int'(reg_addr) == 1) er = DW'(m_pend);
         else if (int'(reg_addr) < 2 + N) er = m_vec[int'(reg_addr) - 2];
         else er = '0;
         chk("R8 reg_rdata", 32'(reg_rdata), 32'(er));
      end
   end

   task automatic cyc(input logic [N-1:0] rq, input logic ak, input logic w,
                      input int a, input logic [DW-1:0] d);
      @(posedge clk); #1;
      irq_req = rq; irq_ack = ak; reg_wr = w; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk); #0.5;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc('0, 0, 0, 0, 0);
      chk("R1 mask reset", 32'(reg_rdata), 32'h00FF);
      chk("R1 irq_out reset", 32'(irq_out), 0);
      cyc('0, 0, 0, 1, 0);
      chk("R1 pending reset", 32'(reg_rdata), 0);
      cyc('0, 0, 0, 2, 0);
      chk("R1 vector reset", 32'(reg_rdata), 0);
      for (int i = 0; i < N; i++) cyc('0, 0, 1, 2 + i, DW'(16'h1000 + 16 * i));
      cyc('0, 0, 0, 5, 0);
      chk("R8 vector readback", 32'(reg_rdata), 32'h1030);
      cyc(8'h20, 0, 0, 1, 0);
      cyc(8'h00, 0, 0, 1, 0);
      chk("R2 pending latched", 32'(reg_rdata), 32'h20);
      chk("R3 masked no irq", 32'(irq_out), 0);
      cyc('0, 0, 1, 0, 16'h00DF);
      cyc('0, 0, 0, 1, 0);
      chk("R4 irq after unmask", 32'(irq_out), 1);
      chk("R2 pending held", 32'(reg_rdata), 32'h20);
      cyc(8'h44, 0, 1, 0, 16'h0000);
      cyc('0, 0, 0, 1, 0);
      chk("R2 pending multi", 32'(reg_rdata), 32'h64);
      chk("R5 lowest wins", 32'(irq_vector), 32'h1020);
      cyc('0, 1, 0, 1, 0);
      chk("R6 vector at ack", 32'(irq_vector), 32'h1020);
      chk("R6 valid at ack", 32'(irq_vec_valid), 1);
      cyc('0, 0, 1, 1, 16'h00FF);
      chk("R7 cleared on ack", 32'(reg_rdata), 32'h60);
      chk("R5 next line", 32'(irq_vector), 32'h1050);
      cyc('0, 0, 0, 1, 0);
      chk("R8 pending write ignored", 32'(reg_rdata), 32'h60);
      cyc('0, 1, 0, 1, 0);
      cyc('0, 1, 0, 1, 0);
      cyc('0, 0, 0, 1, 0);
      chk("R7 all cleared", 32'(reg_rdata), 0);
      chk("R4 irq low", 32'(irq_out), 0);
      cyc('0, 1, 0, 1, 0);
      chk("R9 idle ack valid", 32'(irq_vec_valid), 0);
      cyc('0, 0, 0, 1, 0);
      chk("R9 idle ack no change", 32'(reg_rdata), 0);
      cyc(8'h02, 0, 0, 1, 0);
      cyc(8'h02, 1, 0, 1, 0);
      chk("R6 level vector", 32'(irq_vector), 32'h1010);
      cyc(8'h02, 0, 0, 1, 0);
      chk("R7 clear beats held request", 32'(reg_rdata), 0);
      cyc(8'h02, 0, 0, 1, 0);
      chk("R7 re-armed", 32'(reg_rdata), 32'h02);
      cyc(8'h00, 0, 1, 0, 16'h0002);
      cyc('0, 0, 0, 1, 0);
      chk("R3 masked pending kept", 32'(reg_rdata), 32'h02);
      chk("R3 masked irq low", 32'(irq_out), 0);
      cyc('0, 1, 0, 1, 0);
      chk("R9 ack while masked", 32'(irq_vec_valid), 0);
      cyc('0, 0, 0, 1, 0);
      chk("R9 pending kept", 32'(reg_rdata), 32'h02);
      cyc('0, 0, 0, 12, 0);
      chk("R8 unmapped zero", 32'(reg_rdata), 0);
      lf = 8'h5A;
      for (int k = 0; k < 300; k++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         cyc(lf & {lf[0], lf[7:1]}, lf[2], lf[6] & lf[1], int'(lf[3:0]) % 11, {lf, ~lf});
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule